// File: doc/BRIEF.md
# Masked packed FP32 divide unit

This block divides a vector of single-precision values lane by lane. Each result lane is the first-source lane divided by the matching second-source lane. A vector is 128, 256 or 512 bits wide, which is 4, 8 or 16 lanes of 32 bits. Lane i occupies bits [32i+31:32i].

The second operand is either a full vector or one 32-bit value copied to every lane. Results go into the destination under a per-lane mask. A masked-off lane either keeps the old destination lane (merge) or is cleared (zeroing). Destination bits above the operation width follow the selected mode: one mode keeps the first source's upper bits, and the others clear them.

A single iterative restoring mantissa divider serves the active lanes one after another. It produces one quotient bit per cycle. Special operands are resolved without using the divider. A caller pulses `start_i` with every operand and control value present. It then waits for the one-cycle `done_o` pulse, after which the full 512-bit `result_o` is valid and stays unchanged until the next accepted start.

Top module: `vdiv_unit`

## Requirements
- R1: Each active lane holds the first-source lane divided by the second-source lane, rounded to nearest with ties to even in IEEE single format.
- R2: With mode_i = 0 (keep-upper), 4 lanes are computed, and mask_i, bcast_i and zero_i have no effect. result_o[511:128] equals src1_i[511:128].
- R3: With mode_i = 1 (clear-upper), width_i = 0 gives 4 lanes and any other width_i gives 8 lanes. mask_i, bcast_i and zero_i have no effect, and every bit above the operation width is 0.
- R4: With mode_i = 2 or 3 (masked), width_i = 0, 1 and 2/3 give 4, 8 and 16 lanes, and every bit above the operation width is 0.
- R5: In masked mode with bcast_i = 1, every lane uses src2_i[31:0] as its divisor.
- R6: In masked mode, a lane inside the width with mask_i[i] = 0 and zero_i = 0 equals dst_i lane i.
- R7: In masked mode, a lane inside the width with mask_i[i] = 0 and zero_i = 1 is 0.
- R8: NaN handling: a NaN dividend gives that value with bit 22 set. Otherwise a NaN divisor gives that value with bit 22 set. 0/0 and inf/inf give 0x7FC00000.
- R9: A finite or infinite dividend over zero gives an infinity, and inf over a finite value gives an infinity. Zero over a non-zero value and finite over inf give a zero. All of these results carry the XOR of the operand signs.
- R10: Inputs with a zero exponent field count as signed zeros. A rounded result whose exponent falls below 1 becomes a signed zero, and one above 254 becomes a signed infinity.
- R11: busy_o rises the cycle after an accepted start and stays high until done_o, which is a single-cycle pulse with busy_o low. A start while busy_o is high is ignored, and a start during the done_o cycle is accepted.
- R12: While busy_o is low, result_o changes only after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse that latches all operands and controls |
| mode_i | input | 2 | 0 keep-upper, 1 clear-upper, 2/3 masked |
| width_i | input | 2 | 0: 128 bits, 1: 256 bits, 2/3: 512 bits |
| bcast_i | input | 1 | Broadcast src2_i[31:0] to all lanes (masked mode only) |
| zero_i | input | 1 | Clear masked-off lanes instead of merging (masked mode only) |
| mask_i | input | 16 | Per-lane enable, bit i for lane i (masked mode only) |
| src1_i | input | 512 | Dividend vector |
| src2_i | input | 512 | Divisor vector |
| dst_i | input | 512 | Previous destination, used for merged lanes |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse; result_o is valid |
| result_o | output | 512 | Destination value |

## Verification
The end of one operation and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `start_i` with new operands in the very cycle where `done_o` is seen. It then judges both results against the model, and checks that `busy_o` rises at once. A second overlap is a start arriving in the middle of a long 16-lane operation. The bench drives different operands at that point and requires the result to match the first operation only.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;
  localparam int unsigned LANE_W    = 32;
  localparam int unsigned MAX_LANES = 16;
  localparam int unsigned VEC_W     = LANE_W * MAX_LANES;
  localparam int unsigned MANT_W    = 24;
  localparam int unsigned QUO_W     = MANT_W + 2;
  localparam int unsigned EXP_W     = 10;
  localparam logic [LANE_W-1:0] DEF_QNAN = 32'h7FC0_0000;

  typedef enum logic [1:0] {
    MODE_KEEP   = 2'd0,
    MODE_CLEAR  = 2'd1,
    MODE_MASK   = 2'd2,
    MODE_MASK_B = 2'd3
  } enc_mode_e;

  typedef struct packed {
    logic                     special;
    logic [LANE_W-1:0]        spec_val;
    logic                     sign;
    logic signed [EXP_W-1:0]  exp_b;
    logic [MANT_W-1:0]        ma;
    logic [MANT_W-1:0]        mb;
  } lane_prep_t;

  function automatic logic [4:0] lane_count(logic [1:0] mode, logic [1:0] width);
    logic [4:0] n;
    if (mode == MODE_KEEP)       n = 5'd4;
    else if (mode == MODE_CLEAR) n = (width == 2'd0) ? 5'd4 : 5'd8;
    else if (width == 2'd0)      n = 5'd4;
    else if (width == 2'd1)      n = 5'd8;
    else                         n = 5'd16;
    return n;
  endfunction
endpackage

// File: rtl/vdiv_lane_prep.sv
module vdiv_lane_prep
  import vdiv_pkg::*;
(
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output lane_prep_t        prep_o
);
  logic       sa, sb;
  logic [7:0] ea, eb;
  logic [22:0] fa, fb;
  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;

  assign sa = a_i[31];
  assign sb = b_i[31];
  assign ea = a_i[30:23];
  assign eb = b_i[30:23];
  assign fa = a_i[22:0];
  assign fb = b_i[22:0];

  // zero exponent field counts as zero (flush)
  assign a_zero = (ea == 8'h00);
  assign b_zero = (eb == 8'h00);
  assign a_inf  = (ea == 8'hFF) && (fa == '0);
  assign b_inf  = (eb == 8'hFF) && (fb == '0);
  assign a_nan  = (ea == 8'hFF) && (fa != '0);
  assign b_nan  = (eb == 8'hFF) && (fb != '0);

  always_comb begin
    prep_o          = '0;
    prep_o.sign     = sa ^ sb;
    prep_o.exp_b    = $signed({2'b00, ea}) - $signed({2'b00, eb}) + 10'sd127;
    prep_o.ma       = {1'b1, fa};
    prep_o.mb       = {1'b1, fb};
    if (a_nan) begin
      prep_o.special  = 1'b1;
      prep_o.spec_val = a_i | 32'h0040_0000;
    end else if (b_nan) begin
      prep_o.special  = 1'b1;
      prep_o.spec_val = b_i | 32'h0040_0000;
    end else if ((a_zero && b_zero) || (a_inf && b_inf)) begin
      prep_o.special  = 1'b1;
      prep_o.spec_val = DEF_QNAN;
    end else if (a_inf || b_zero) begin
      prep_o.special  = 1'b1;
      prep_o.spec_val = {sa ^ sb, 8'hFF, 23'd0};
    end else if (a_zero || b_inf) begin
      prep_o.special  = 1'b1;
      prep_o.spec_val = {sa ^ sb, 31'd0};
    end
  end
endmodule

// File: rtl/vdiv_mant_div.sv
module vdiv_mant_div #(
  parameter int unsigned MW = 24,
  parameter int unsigned QW = MW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] num_i,
  input  logic [MW-1:0] den_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [QW-1:0] quo_o,
  output logic          rem_nz_o
);
  localparam int unsigned CW = $clog2(QW);
  localparam int unsigned RW = MW + 2;

  logic [RW-1:0] rem_q;
  logic [MW-1:0] den_q;
  logic [QW-1:0] quo_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic          ge;
  logic [RW-1:0] diff, rem_nx;

  assign ge     = (rem_q >= {2'b00, den_q});
  assign diff   = rem_q - {2'b00, den_q};
  assign rem_nx = ge ? diff : rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= {2'b00, num_i};
        den_q  <= den_i;
        quo_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quo_q <= {quo_q[QW-2:0], ge};
        rem_q <= {rem_nx[RW-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(QW - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign quo_o    = quo_q;
  assign rem_nz_o = |rem_q;
endmodule

// File: rtl/vdiv_round.sv
module vdiv_round
  import vdiv_pkg::*;
(
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [QUO_W-1:0]        quo_i,
  input  logic                    rem_nz_i,
  output logic [LANE_W-1:0]       val_o
);
  logic [MANT_W-1:0]       m;
  logic [MANT_W:0]         mr;
  logic [MANT_W-2:0]       frac;
  logic                    g, s, up;
  logic signed [EXP_W-1:0] e;

  always_comb begin
    if (quo_i[QUO_W-1]) begin
      m = quo_i[QUO_W-1:2];
      g = quo_i[1];
      s = quo_i[0] | rem_nz_i;
      e = exp_i;
    end else begin
      m = quo_i[QUO_W-2:1];
      g = quo_i[0];
      s = rem_nz_i;
      e = exp_i - 10'sd1;
    end
    up = g & (s | m[0]);
    mr = {1'b0, m} + {{MANT_W{1'b0}}, up};
    if (mr[MANT_W]) begin
      e    = e + 10'sd1;
      frac = '0;
    end else begin
      frac = mr[MANT_W-2:0];
    end
    if (e > 10'sd254)     val_o = {sign_i, 8'hFF, 23'd0};
    else if (e < 10'sd1)  val_o = {sign_i, 31'd0};
    else                  val_o = {sign_i, e[7:0], frac};
  end
endmodule

// File: rtl/vdiv_unit.sv
module vdiv_unit
  import vdiv_pkg::*;
#(
  parameter int unsigned NUM_LANES = MAX_LANES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [1:0]              mode_i,
  input  logic [1:0]              width_i,
  input  logic                    bcast_i,
  input  logic                    zero_i,
  input  logic [NUM_LANES-1:0]    mask_i,
  input  logic [NUM_LANES*32-1:0] src1_i,
  input  logic [NUM_LANES*32-1:0] src2_i,
  input  logic [NUM_LANES*32-1:0] dst_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [NUM_LANES*32-1:0] result_o
);
  localparam int unsigned VW    = NUM_LANES * LANE_W;
  localparam int unsigned IDX_W = $clog2(NUM_LANES);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DIV, ST_DONE} st_e;

  st_e                  st_q;
  logic [VW-1:0]        src1_q, src2_q, res_q;
  logic                 bcast_q;
  logic [NUM_LANES-1:0] act_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 sign_q;
  logic signed [EXP_W-1:0] exp_q;

  logic                 accept;
  logic [4:0]           nl_n;
  logic                 masked_n;
  logic [NUM_LANES-1:0] act_n;
  logic [VW-1:0]        init_n;
  logic [LANE_W-1:0]    lane_a, lane_b, rnd_val;
  lane_prep_t           prep;
  logic                 div_start, div_busy, div_done, div_rem_nz;
  logic [QUO_W-1:0]     div_quo;
  logic                 last_lane;

  assign accept   = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign nl_n     = lane_count(mode_i, width_i);
  assign masked_n = mode_i[1];

  // initial destination image: out-of-width, masked-off and placeholder lanes
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_init
    logic in_w, en;
    assign in_w     = (5'(g) < nl_n);
    assign en       = in_w && (masked_n ? mask_i[g] : 1'b1);
    assign act_n[g] = en;
    assign init_n[g*LANE_W +: LANE_W] =
        !in_w ? ((mode_i == MODE_KEEP) ? src1_i[g*LANE_W +: LANE_W] : '0) :
        (en || zero_i) ? '0 : dst_i[g*LANE_W +: LANE_W];
  end

  assign lane_a = src1_q[idx_q*LANE_W +: LANE_W];
  assign lane_b = bcast_q ? src2_q[LANE_W-1:0] : src2_q[idx_q*LANE_W +: LANE_W];

  vdiv_lane_prep u_prep (
    .a_i    (lane_a),
    .b_i    (lane_b),
    .prep_o (prep)
  );

  assign div_start = (st_q == ST_SCAN) && act_q[idx_q] && !prep.special;

  vdiv_mant_div #(.MW(MANT_W), .QW(QUO_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (div_start),
    .num_i    (prep.ma),
    .den_i    (prep.mb),
    .busy_o   (div_busy),
    .done_o   (div_done),
    .quo_o    (div_quo),
    .rem_nz_o (div_rem_nz)
  );

  vdiv_round u_round (
    .sign_i   (sign_q),
    .exp_i    (exp_q),
    .quo_i    (div_quo),
    .rem_nz_i (div_rem_nz),
    .val_o    (rnd_val)
  );

  assign last_lane = (idx_q == IDX_W'(NUM_LANES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      src1_q  <= '0;
      src2_q  <= '0;
      res_q   <= '0;
      bcast_q <= 1'b0;
      act_q   <= '0;
      idx_q   <= '0;
      sign_q  <= 1'b0;
      exp_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            src1_q  <= src1_i;
            src2_q  <= src2_i;
            bcast_q <= bcast_i && masked_n;
            act_q   <= act_n;
            res_q   <= init_n;
            idx_q   <= '0;
            st_q    <= ST_SCAN;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_SCAN: begin
          if (act_q[idx_q] && !prep.special) begin
            sign_q <= prep.sign;
            exp_q  <= prep.exp_b;
            st_q   <= ST_DIV;
          end else begin
            if (act_q[idx_q]) res_q[idx_q*LANE_W +: LANE_W] <= prep.spec_val;
            if (last_lane) st_q <= ST_DONE;
            else           idx_q <= idx_q + 1'b1;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            res_q[idx_q*LANE_W +: LANE_W] <= rnd_val;
            if (last_lane) begin
              st_q <= ST_DONE;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_SCAN;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q == ST_SCAN) || (st_q == ST_DIV);
  assign done_o   = (st_q == ST_DONE);
  assign result_o = res_q;
endmodule

// File: rtl/vdiv_unit_chk.sv
module vdiv_unit_chk #(
  parameter int unsigned VW = 512
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [VW-1:0] result_o
);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R11
  start_to_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R11
  busy_until_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
  // R11
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  // R12
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(result_o));
endmodule

bind vdiv_unit vdiv_unit_chk #(.VW(NUM_LANES*32)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/vdiv_unit_tb_top.sv
`timescale 1ns/1ps
module vdiv_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = '0, width = '0;
  logic         bcast = 1'b0, zero = 1'b0;
  logic [15:0]  mask = '0;
  logic [511:0] src1 = '0, src2 = '0, dst = '0;
  logic         busy, done;
  logic [511:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  vdiv_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .width_i(width),
    .bcast_i(bcast), .zero_i(zero), .mask_i(mask), .src1_i(src1), .src2_i(src2),
    .dst_i(dst), .busy_o(busy), .done_o(done), .result_o(result)
  );

  function automatic logic [63:0] to_dbl(logic [31:0] f);
    return {f[31], 11'(f[30:23]) + 11'd896, f[22:0], 29'd0};
  endfunction

  function automatic logic [31:0] ref_div(logic [31:0] a, logic [31:0] b);
    logic sa, sb, s, az, bz, ai, bi, an, bn, g, st, up;
    logic [63:0] qb;
    logic [24:0] m;
    int e;
    real q;
    sa = a[31]; sb = b[31]; s = sa ^ sb;
    az = (a[30:23] == 0); bz = (b[30:23] == 0);
    ai = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    bi = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    if (an) return a | 32'h0040_0000;
    if (bn) return b | 32'h0040_0000;
    if ((az && bz) || (ai && bi)) return 32'h7FC0_0000;
    if (ai || bz) return {s, 8'hFF, 23'd0};
    if (az || bi) return {s, 31'd0};
    q  = $bitstoreal(to_dbl(a)) / $bitstoreal(to_dbl(b));
    qb = $realtobits(q);
    e  = int'(qb[62:52]) - 1023 + 127;
    m  = {2'b01, qb[51:29]};
    g  = qb[28];
    st = |qb[27:0];
    up = g & (st | m[0]);
    m  = m + 25'(up);
    if (m[24]) begin e = e + 1; m = 25'h0800000; end
    if (e > 254) return {s, 8'hFF, 23'd0};
    if (e < 1)   return {s, 31'd0};
    return {s, 8'(e), m[22:0]};
  endfunction

  function automatic logic [511:0] ref_vec(logic [1:0] md, logic [1:0] wd, logic bc, logic zr,
                                           logic [15:0] mk, logic [511:0] a, logic [511:0] b,
                                           logic [511:0] d);
    logic [511:0] r;
    int nl;
    logic on;
    logic [31:0] bl;
    if (md == 0) nl = 4;
    else if (md == 1) nl = (wd == 0) ? 4 : 8;
    else nl = (wd == 0) ? 4 : (wd == 1) ? 8 : 16;
    for (int i = 0; i < 16; i++) begin
      on = (md[1]) ? mk[i] : 1'b1;
      bl = (md[1] && bc) ? b[31:0] : b[i*32 +: 32];
      if (i >= nl)      r[i*32 +: 32] = (md == 0) ? a[i*32 +: 32] : 32'd0;
      else if (on)      r[i*32 +: 32] = ref_div(a[i*32 +: 32], bl);
      else if (zr)      r[i*32 +: 32] = 32'd0;
      else              r[i*32 +: 32] = d[i*32 +: 32];
    end
    return r;
  endfunction

  function automatic logic [31:0] rnd_f();
    int unsigned k;
    logic s;
    k = $urandom % 16;
    s = 1'($urandom);
    case (k)
      0: return {s, 31'd0};
      1: return {s, 8'hFF, 23'd0};
      2: return {s, 8'hFF, 23'($urandom) | 23'h1};
      3: return {s, 8'h00, 23'($urandom) | 23'h1};
      4: return {s, 8'(1 + $urandom % 8), 23'($urandom)};
      5: return {s, 8'(246 + $urandom % 9), 23'($urandom)};
      default: return {s, 8'(64 + $urandom % 128), 23'($urandom)};
    endcase
  endfunction

  function automatic logic [511:0] rnd_vec();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = rnd_f();
    return v;
  endfunction

  task automatic chk1(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic chk_vec(string tag, logic [511:0] got, logic [511:0] exp);
    for (int i = 0; i < 16; i++) begin
      n_chk++;
      if (got[i*32 +: 32] !== exp[i*32 +: 32]) begin
        n_bad++;
        $display("FAIL %s lane %0d got %h exp %h", tag, i, got[i*32 +: 32], exp[i*32 +: 32]);
      end
    end
  endtask

  task automatic set_in(logic [1:0] md, logic [1:0] wd, logic bc, logic zr, logic [15:0] mk,
                        logic [511:0] a, logic [511:0] b, logic [511:0] d);
    mode = md; width = wd; bcast = bc; zero = zr; mask = mk; src1 = a; src2 = b; dst = d;
  endtask

  task automatic pulse();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic [511:0] r);
    while (!done) @(negedge clk);
    r = result;
  endtask

  task automatic run(string tag, logic [1:0] md, logic [1:0] wd, logic bc, logic zr,
                     logic [15:0] mk, logic [511:0] a, logic [511:0] b, logic [511:0] d,
                     output logic [511:0] r);
    set_in(md, wd, bc, zr, mk, a, b, d);
    pulse();
    wait_done(r);
    chk_vec(tag, r, ref_vec(md, wd, bc, zr, mk, a, b, d));
    @(negedge clk);
    chk1({tag, " R11 done width"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog R11 got hung exp done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [511:0] a, b, d, r, r2, ea, eb;
    logic [15:0]  mk;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 R12 reset state
    chk1("R11 reset busy", {31'd0, busy}, 32'd0);
    chk1("R11 reset done", {31'd0, done}, 32'd0);
    chk_vec("R12 reset result", result, '0);

    // R1 directed literals: 6/3, 1/3, -1/3, 1/1
    a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
    a[31:0] = 32'h40C0_0000; b[31:0] = 32'h4040_0000;
    a[63:32] = 32'h3F80_0000; b[63:32] = 32'h4040_0000;
    a[95:64] = 32'hBF80_0000; b[95:64] = 32'h4040_0000;
    a[127:96] = 32'h3F80_0000; b[127:96] = 32'h3F80_0000;
    run("R1 directed", 2'd2, 2'd2, 1'b0, 1'b0, 16'hFFFF, a, b, d, r);
    chk1("R1 6/3", r[31:0], 32'h4000_0000);
    chk1("R1 1/3", r[63:32], 32'h3EAA_AAAB);
    chk1("R1 -1/3", r[95:64], 32'hBEAA_AAAB);
    chk1("R1 1/1", r[127:96], 32'h3F80_0000);

    // R2 keep-upper: mask/bcast/zero ignored, upper = src1
    a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
    run("R2 keep", 2'd0, 2'd2, 1'b1, 1'b1, 16'h0000, a, b, d, r);
    chk_vec("R2 upper", {r[511:128], 128'd0}, {a[511:128], 128'd0});

    // R3 clear-upper 128 and 256
    a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
    run("R3 clear 128", 2'd1, 2'd0, 1'b1, 1'b1, 16'h0000, a, b, d, r);
    run("R3 clear 256", 2'd1, 2'd3, 1'b1, 1'b0, 16'h0001, a, b, d, r);
    chk_vec("R3 upper zero", {r[511:256], 256'd0}, '0);

    // R4 masked widths
    a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
    run("R4 mask 512", 2'd2, 2'd2, 1'b0, 1'b0, 16'hFFFF, a, b, d, r);
    run("R4 mask 256", 2'd3, 2'd1, 1'b0, 1'b0, 16'hFFFF, a, b, d, r);
    run("R4 mask 128", 2'd2, 2'd0, 1'b0, 1'b1, 16'hFFFF, a, b, d, r);

    // R5 broadcast
    a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
    b[31:0] = 32'h4040_0000;
    run("R5 bcast", 2'd2, 2'd2, 1'b1, 1'b0, 16'hFFFF, a, b, d, r);

    // R6 merge / R7 zeroing
    a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
    run("R6 merge", 2'd2, 2'd2, 1'b0, 1'b0, 16'h5A3C, a, b, d, r);
    chk1("R6 lane0 kept", r[31:0], d[31:0]);
    run("R7 zeroing", 2'd2, 2'd2, 1'b0, 1'b1, 16'h5A3C, a, b, d, r);
    chk1("R7 lane0 cleared", r[31:0], 32'd0);

    // R8 R9 specials
    a = '0; b = '0; d = rnd_vec();
    a[31:0]    = 32'h7F80_0001; b[31:0]    = 32'hFFC0_1234;
    a[63:32]   = 32'h3F80_0000; b[63:32]   = 32'hFF80_0055;
    a[95:64]   = 32'h8000_0000; b[95:64]   = 32'h0000_0000;
    a[127:96]  = 32'h7F80_0000; b[127:96]  = 32'hFF80_0000;
    a[159:128] = 32'hC000_0000; b[159:128] = 32'h8000_0000;
    a[191:160] = 32'h7F80_0000; b[191:160] = 32'h4000_0000;
    a[223:192] = 32'h8000_0000; b[223:192] = 32'h4000_0000;
    a[255:224] = 32'h4000_0000; b[255:224] = 32'hFF80_0000;
    run("R8 R9 specials", 2'd2, 2'd1, 1'b0, 1'b0, 16'hFFFF, a, b, d, r);
    chk1("R8 nan a", r[31:0], 32'h7FC0_0001);
    chk1("R8 nan b", r[63:32], 32'hFFC0_0055);
    chk1("R8 0/0", r[95:64], 32'h7FC0_0000);
    chk1("R8 inf/inf", r[127:96], 32'h7FC0_0000);
    chk1("R9 x/0", r[159:128], 32'h7F80_0000);
    chk1("R9 inf/x", r[191:160], 32'h7F80_0000);
    chk1("R9 0/x", r[223:192], 32'h8000_0000);
    chk1("R9 x/inf", r[255:224], 32'h8000_0000);

    // R10 flush and overflow
    a = rnd_vec(); b = rnd_vec();
    a[31:0]  = 32'h0040_0000; b[31:0]  = 32'h3F80_0000;
    a[63:32] = 32'h7F00_0000; b[63:32] = 32'h0080_0000;
    a[95:64] = 32'h8080_0000; b[95:64] = 32'h4000_0000;
    a[127:96] = 32'h3F80_0000; b[127:96] = 32'h0000_0001;
    run("R10 range", 2'd1, 2'd0, 1'b0, 1'b0, 16'hFFFF, a, b, d, r);
    chk1("R10 sub in", r[31:0], 32'h0000_0000);
    chk1("R10 overflow", r[63:32], 32'h7F80_0000);
    chk1("R10 underflow", r[95:64], 32'h8000_0000);
    chk1("R10 sub divisor", r[127:96], 32'h7F80_0000);

    // R11 back-to-back: start in the done cycle
    a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
    set_in(2'd2, 2'd0, 1'b0, 1'b0, 16'hFFFF, a, b, d);
    pulse();
    wait_done(r);
    chk_vec("R11 b2b first", r, ref_vec(2'd2, 2'd0, 1'b0, 1'b0, 16'hFFFF, a, b, d));
    ea = rnd_vec(); eb = rnd_vec();
    set_in(2'd1, 2'd1, 1'b0, 1'b0, 16'h0000, ea, eb, d);
    pulse();
    chk1("R11 b2b accepted", {31'd0, busy}, 32'd1);
    wait_done(r2);
    chk_vec("R11 b2b second", r2, ref_vec(2'd1, 2'd1, 1'b0, 1'b0, 16'h0000, ea, eb, d));
    @(negedge clk);

    // R11 start while busy is ignored
    a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
    set_in(2'd2, 2'd2, 1'b0, 1'b0, 16'hFFFF, a, b, d);
    pulse();
    repeat (40) @(negedge clk);
    set_in(2'd0, 2'd0, 1'b0, 1'b0, 16'h0000, rnd_vec(), rnd_vec(), rnd_vec());
    pulse();
    wait_done(r);
    chk_vec("R11 busy start ignored", r, ref_vec(2'd2, 2'd2, 1'b0, 1'b0, 16'hFFFF, a, b, d));
    // R12 hold while idle with changing inputs
    repeat (3) @(negedge clk);
    src1 = rnd_vec(); dst = rnd_vec();
    repeat (3) @(negedge clk);
    chk_vec("R12 hold", result, r);

    // R1 random mix
    for (int n = 0; n < 40; n++) begin
      mk = 16'($urandom);
      run("R1 random", 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), mk,
          rnd_vec(), rnd_vec(), rnd_vec(), r);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule